// File: doc/BRIEF.md
# Load/Store Multiple Word Sequencer

This block turns a single load-multiple or store-multiple word operation into a run of one-word memory accesses. It is given a first register index, a 32-bit effective address, a direction and an endian-mode bit. It then walks the registers from the first index up to the top of the register file, one word per register, at word addresses that rise from the effective address.

On a load, each word returned by memory is written into the register file in the cycle the memory accepts the access. On a store, each register is read through a combinational read port and presented as write data. Every access waits for the memory's ready handshake before the sequence moves on.

Alignment is checked once, when the operation is accepted. A misaligned address ends the operation with an exception pulse and no memory access. The address sequence is computed only from the effective address latched at start. The base register therefore needs no special handling when it lies inside the load range: it is loaded from its own slot like any other register. When finished, the block gives a one-cycle completion pulse.

Top module: `lsm_seq`

## Requirements
- R1: If the two low bits of `ea_i` are not both zero when an operation is accepted, `align_exc_o` is high for exactly the one cycle after acceptance, and no memory request is made.
- R2: For an aligned operation with first register f, registers f, f+1, ..., 31 are transferred in ascending order, register n at address `ea_i + (n - f) * 4`, giving exactly 32 - f accesses.
- R3: While `mem_req_o` is high and `mem_rdy_i` is low, the next cycle still requests with the same `mem_addr_o` and `mem_we_o`; an access completes only in a cycle with `mem_rdy_i` high.
- R4: A load whose base register rA lies in f..31 completes normally, and rA receives the word at `ea_i + (rA - f) * 4`; the addresses that follow are unaffected.
- R5: `little_end_i` does not change the outcome: misaligned addresses raise the exception in both modes, and aligned transfers move the same words to the same places.
- R6: `done_o` and `align_exc_o` are never high together, each is a one-cycle pulse, and `done_o` rises in the cycle after the last access is accepted.
- R7: A store (`store_i` = 1) drives `mem_we_o` = 1, presents register n on `rf_ridx_o`, forwards `rf_rdata_i` to `mem_wdata_o`, and never asserts `rf_we_o`.
- R8: A load (`store_i` = 0) asserts `rf_we_o` with `rf_widx_o` = n and `rf_wdata_o` = `mem_rdata_i` in the cycle its access is accepted.
- R9: A first register of 31 transfers exactly one word.
- R10: After reset the block is idle, with `busy_o`, `mem_req_o`, `done_o` and `align_exc_o` low. `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start an operation (taken only when idle) |
| store_i | input | 1 | 1 = store-multiple, 0 = load-multiple |
| first_reg_i | input | 5 | First register index f |
| ea_i | input | 32 | Effective address |
| little_end_i | input | 1 | Little-endian mode |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| align_exc_o | output | 1 | One-cycle alignment exception pulse |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Memory write (store) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_rdy_i | input | 1 | Memory accepts the current request |
| rf_we_o | output | 1 | Register-file write enable |
| rf_widx_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| rf_ridx_o | output | 5 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data (combinational) |

## Verification
The assertions check on every cycle that:
- the two status pulses never overlap and last one cycle;
- an exception follows an accepted start;
- a stalled request holds its address and direction;
- consecutive accepted accesses step the address by one word;
- a store never writes the register file.

Only the bench's scenarios can show the rest, by comparing the final register file and memory against a model computed from the requirements:
- that the right words land in the right registers and memory slots;
- that the base register inside the load range gets its own slot's word;
- that the access count is 32 - f;
- that the endian bit and a start issued mid-operation leave results unchanged.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_FIN  = 2'd2,
      ST_EXC  = 2'd3
   } lsm_state_e;

   localparam int unsigned LSM_ADDR_INCR   = 0;
   localparam int unsigned LSM_ADDR_OFFSET = 1;
endpackage

// File: rtl/lsm_align_chk.sv
module lsm_align_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned WORD_BYTES = 4,
   localparam int unsigned LOW_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
   input  logic [ADDR_W-1:0] ea_i,
   input  logic              little_end_i,
   output logic              misaligned_o
);
   // Endian mode does not relax the word-alignment rule for multiple transfers.
   logic unused_endian;
   assign unused_endian = little_end_i;

   generate
      if (WORD_BYTES > 1) begin : g_chk
         assign misaligned_o = |ea_i[LOW_W-1:0];
      end else begin : g_byte
         logic unused_low;
         assign unused_low   = ea_i[0];
         assign misaligned_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
   import lsm_pkg::*;
#(
   parameter int unsigned REG_CNT = 32,
   localparam int unsigned IDX_W  = $clog2(REG_CNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             store_i,
   input  logic [IDX_W-1:0] first_i,
   input  logic             misaligned_i,
   input  logic             rdy_i,
   output logic             accept_o,
   output logic             busy_o,
   output logic             req_o,
   output logic             we_o,
   output logic             beat_o,
   output logic             last_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             done_o,
   output logic             exc_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REG_CNT - 1);

   lsm_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             store_q;

   assign accept_o = start_i && (state_q == ST_IDLE);
   assign busy_o   = (state_q != ST_IDLE);
   assign req_o    = (state_q == ST_XFER);
   assign we_o     = req_o && store_q;
   assign beat_o   = req_o && rdy_i;
   assign last_o   = (idx_q == LAST_IDX);
   assign idx_o    = idx_q;
   assign done_o   = (state_q == ST_FIN);
   assign exc_o    = (state_q == ST_EXC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         store_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  store_q <= store_i;
                  idx_q   <= first_i;
                  state_q <= misaligned_i ? ST_EXC : ST_XFER;
               end
            end
            ST_XFER: begin
               if (rdy_i) begin
                  if (idx_q == LAST_IDX) state_q <= ST_FIN;
                  else                   idx_q   <= idx_q + 1'b1;
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            ST_EXC:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R6: status pulses exclusive and single-cycle
   a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && exc_o));
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r6_exc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      exc_o |=> !exc_o);
   // R6: completion only after an accepted final access
   a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(beat_o && last_o));
endmodule

// File: rtl/lsm_addr_gen.sv
module lsm_addr_gen
   import lsm_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned REG_CNT    = 32,
   parameter int unsigned STYLE      = LSM_ADDR_INCR,
   localparam int unsigned IDX_W     = $clog2(REG_CNT),
   localparam int unsigned LOW_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] ea_i,
   input  logic [IDX_W-1:0]  first_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              beat_i,
   input  logic              last_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   generate
      if (STYLE == LSM_ADDR_INCR) begin : g_incr
         logic [ADDR_W-1:0] addr_q;
         logic              unused_idx;
         assign unused_idx = ^{first_i, idx_i};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      addr_q <= '0;
            else if (load_i) addr_q <= ea_i;
            else if (beat_i) addr_q <= addr_q + STEP;
         end
         assign addr_o = addr_q;
      end else begin : g_offset
         logic [ADDR_W-1:0] base_q;
         logic [IDX_W-1:0]  first_q;
         logic [ADDR_W-1:0] offs;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               base_q  <= '0;
               first_q <= '0;
            end else if (load_i) begin
               base_q  <= ea_i;
               first_q <= first_i;
            end
         end
         assign offs   = ADDR_W'(idx_i - first_q) << LOW_W;
         assign addr_o = base_q + offs;
      end
   endgenerate

   // R2: each accepted non-final access is followed by the next word address
   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_i && !last_i) |=> (addr_o == $past(addr_o) + STEP));
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
   import lsm_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned REG_CNT    = 32,
   parameter int unsigned ADDR_STYLE = LSM_ADDR_INCR,
   localparam int unsigned IDX_W     = $clog2(REG_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              store_i,
   input  logic [IDX_W-1:0]  first_reg_i,
   input  logic [ADDR_W-1:0] ea_i,
   input  logic              little_end_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              align_exc_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_rdy_i,
   output logic              rf_we_o,
   output logic [IDX_W-1:0]  rf_widx_o,
   output logic [DATA_W-1:0] rf_wdata_o,
   output logic [IDX_W-1:0]  rf_ridx_o,
   input  logic [DATA_W-1:0] rf_rdata_i
);
   initial begin
      assert (REG_CNT >= 2 && (REG_CNT & (REG_CNT - 1)) == 0)
         else $error("lsm_seq: REG_CNT must be a power of two >= 2");
      assert (WORD_BYTES >= 1 && (WORD_BYTES & (WORD_BYTES - 1)) == 0)
         else $error("lsm_seq: WORD_BYTES must be a power of two");
      assert (DATA_W == 8 * WORD_BYTES)
         else $error("lsm_seq: DATA_W must equal 8*WORD_BYTES");
      assert (ADDR_STYLE == LSM_ADDR_INCR || ADDR_STYLE == LSM_ADDR_OFFSET)
         else $error("lsm_seq: unknown ADDR_STYLE");
   end

   logic             misaligned;
   logic             accept;
   logic             beat;
   logic             last;
   logic [IDX_W-1:0] idx;

   lsm_align_chk #(
      .ADDR_W     (ADDR_W),
      .WORD_BYTES (WORD_BYTES)
   ) u_align (
      .ea_i         (ea_i),
      .little_end_i (little_end_i),
      .misaligned_o (misaligned)
   );

   lsm_ctrl #(
      .REG_CNT (REG_CNT)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .store_i      (store_i),
      .first_i      (first_reg_i),
      .misaligned_i (misaligned),
      .rdy_i        (mem_rdy_i),
      .accept_o     (accept),
      .busy_o       (busy_o),
      .req_o        (mem_req_o),
      .we_o         (mem_we_o),
      .beat_o       (beat),
      .last_o       (last),
      .idx_o        (idx),
      .done_o       (done_o),
      .exc_o        (align_exc_o)
   );

   lsm_addr_gen #(
      .ADDR_W     (ADDR_W),
      .WORD_BYTES (WORD_BYTES),
      .REG_CNT    (REG_CNT),
      .STYLE      (ADDR_STYLE)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .ea_i    (ea_i),
      .first_i (first_reg_i),
      .idx_i   (idx),
      .beat_i  (beat),
      .last_i  (last),
      .addr_o  (mem_addr_o)
   );

   // Data paths: loads write the register file as the beat lands; stores forward the read port.
   assign rf_ridx_o   = idx;
   assign rf_widx_o   = idx;
   assign mem_wdata_o = rf_rdata_i;
   assign rf_wdata_o  = mem_rdata_i;
   assign rf_we_o     = beat && !mem_we_o;

   // R1: an exception only follows an accepted start
   a_r1_exc_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(align_exc_o) |-> $past(start_i && !busy_o));
   // R3: a stalled request holds address and direction
   a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
   // R7: a store never writes the register file
   a_r7_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> !rf_we_o);
   // R10: no request or status while idle
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !(mem_req_o || done_o || align_exc_o));
endmodule

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        store_i = 1'b0;
   logic [4:0]  first_reg_i = '0;
   logic [31:0] ea_i = '0;
   logic        little_end_i = 1'b0;
   logic        busy_o, done_o, align_exc_o;
   logic        mem_req_o, mem_we_o;
   logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
   logic        mem_rdy_i = 1'b0;
   logic        rf_we_o;
   logic [4:0]  rf_widx_o, rf_ridx_o;
   logic [31:0] rf_wdata_o, rf_rdata_i;

   always #2.5 clk = ~clk;

   lsm_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .store_i(store_i),
      .first_reg_i(first_reg_i), .ea_i(ea_i), .little_end_i(little_end_i),
      .busy_o(busy_o), .done_o(done_o), .align_exc_o(align_exc_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i),
      .rf_we_o(rf_we_o), .rf_widx_o(rf_widx_o), .rf_wdata_o(rf_wdata_o),
      .rf_ridx_o(rf_ridx_o), .rf_rdata_i(rf_rdata_i)
   );

   logic [31:0] mem [64];
   logic [31:0] rf  [32];
   logic [31:0] exp_mem [64];
   logic [31:0] exp_rf  [32];

   assign mem_rdata_i = mem[mem_addr_o[7:2]];
   assign rf_rdata_i  = rf[rf_ridx_o];

   int total = 0;
   int failed = 0;
   int beats = 0;
   int addr_err = 0;
   int stall_err = 0;
   int idx_err = 0;
   logic [31:0] exp_addr = '0;
   logic [4:0]  exp_idx = '0;
   logic        stall_q = 1'b0;
   logic [31:0] stall_addr = '0;
   int          cyc = 0;
   bit          full_rdy = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      total++;
      if (!ok) begin
         failed++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // ready generator
   always @(negedge clk) mem_rdy_i = full_rdy || ($urandom_range(0, 2) != 0);

   // memory / register file model and access monitor
   always @(posedge clk) begin
      if (rst_n) begin
         if (stall_q && mem_req_o && mem_addr_o != stall_addr) stall_err++;
         stall_q    = mem_req_o && !mem_rdy_i;
         stall_addr = mem_addr_o;
         if (mem_req_o && mem_rdy_i) begin
            beats++;
            if (mem_addr_o != exp_addr) addr_err++;
            if (mem_we_o && rf_ridx_o != exp_idx) idx_err++;
            if (rf_we_o && rf_widx_o != exp_idx) idx_err++;
            exp_addr = exp_addr + 32'd4;
            exp_idx  = exp_idx + 5'd1;
            if (mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
         end
         if (rf_we_o) rf[rf_widx_o] <= rf_wdata_o;
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         total++;
         failed++;
         $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

   task automatic run_op(input bit st, input logic [4:0] first, input logic [31:0] ea,
                         input bit le, input bit poke, input string tag);
      bit mis;
      int n_exp;
      int cycles;
      bit saw_done, saw_exc;
      int rf_bad, mem_bad;
      mis = (ea[1:0] != 2'b00);
      for (int i = 0; i < 64; i++) exp_mem[i] = mem[i];
      for (int i = 0; i < 32; i++) exp_rf[i] = rf[i];
      n_exp = mis ? 0 : 32 - int'(first);
      if (!mis) begin
         for (int n = int'(first); n < 32; n++) begin
            logic [31:0] a;
            a = ea + 32'((n - int'(first)) * 4);
            if (st) exp_mem[a[7:2]] = rf[n];
            else    exp_rf[n]       = mem[a[7:2]];
         end
      end
      @(negedge clk);
      beats = 0; addr_err = 0; stall_err = 0; idx_err = 0;
      exp_addr = ea; exp_idx = first;
      store_i = st; first_reg_i = first; ea_i = ea; little_end_i = le; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cycles = 0;
      while (!done_o && !align_exc_o && cycles < 500) begin
         if (poke && cycles == 2 && busy_o) begin
            start_i = 1'b1; store_i = ~st; first_reg_i = 5'd0; ea_i = ea ^ 32'h3;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         cycles++;
      end
      start_i = 1'b0;
      saw_done = done_o;
      saw_exc  = align_exc_o;
      check(cycles < 500, tag, "operation finished", cycles, 500);
      check(saw_exc == mis && saw_done == !mis, {tag, " R1/R6 status kind"},
            "exc/done", {saw_exc, saw_done}, {mis, !mis});
      @(negedge clk);
      check(!done_o && !align_exc_o && !busy_o, {tag, " R6 single pulse"},
            "pulse after", {done_o, align_exc_o}, 0);
      check(beats == n_exp, {tag, " R2 access count"}, "beats", beats, n_exp);
      check(addr_err == 0 && idx_err == 0, {tag, " R2 address/register order"},
            "errors", addr_err + idx_err, 0);
      check(stall_err == 0, {tag, " R3 stall hold"}, "stall errors", stall_err, 0);
      rf_bad = 0; mem_bad = 0;
      for (int i = 0; i < 32; i++) if (rf[i] !== exp_rf[i]) rf_bad++;
      for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) mem_bad++;
      check(rf_bad == 0, {tag, st ? " R7 rf untouched" : " R8 rf loaded"},
            "rf mismatches", rf_bad, 0);
      check(mem_bad == 0, {tag, st ? " R7 mem stored" : " R8 mem untouched"},
            "mem mismatches", mem_bad, 0);
   endtask

   initial begin
      void'($urandom(32'h1F2E3D));
      for (int i = 0; i < 64; i++) mem[i] = $urandom;
      for (int i = 0; i < 32; i++) rf[i] = $urandom;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!busy_o && !mem_req_o && !done_o && !align_exc_o, "R10 reset idle",
            "outputs", {busy_o, mem_req_o, done_o, align_exc_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !mem_req_o, "R10 idle after reset", "busy/req", {busy_o, mem_req_o}, 0);

      // R4: base register inside the load range
      begin
         logic [31:0] ea, want;
         ea   = 32'h0000_1040;
         want = mem[6'(((ea >> 2) + 5) & 63)];
         run_op(1'b0, 5'd20, ea, 1'b0, 1'b0, "R4 base-in-range");
         check(rf[25] == want, "R4 base reg value", "rf[25]", rf[25], want);
      end
      // R9: single word
      run_op(1'b0, 5'd31, 32'h0000_10F0, 1'b0, 1'b0, "R9 load first=31");
      run_op(1'b1, 5'd31, 32'h0000_1004, 1'b0, 1'b0, "R9 store first=31");
      // R1/R5: misaligned in both endian modes
      run_op(1'b0, 5'd4, 32'h0000_1002, 1'b0, 1'b0, "R1 misaligned BE");
      run_op(1'b1, 5'd4, 32'h0000_1001, 1'b1, 1'b0, "R1 R5 misaligned LE");
      // R5: aligned in LE mode
      run_op(1'b0, 5'd10, 32'h0000_1080, 1'b1, 1'b0, "R5 LE load");
      run_op(1'b1, 5'd12, 32'h0000_1020, 1'b1, 1'b0, "R5 LE store");
      // R7: full store from r0
      run_op(1'b1, 5'd0, 32'h0000_1000, 1'b0, 1'b0, "R7 store all");
      // R10: start ignored while busy
      run_op(1'b0, 5'd8, 32'h0000_1010, 1'b0, 1'b1, "R10 mid-op start");
      run_op(1'b1, 5'd16, 32'h0000_1030, 1'b0, 1'b1, "R10 mid-op start store");
      // R3: always-ready and random-stall mixes
      full_rdy = 1'b1;
      run_op(1'b0, 5'd2, 32'h0000_10A0, 1'b0, 1'b0, "R3 no-stall load");
      full_rdy = 1'b0;
      // random mix
      for (int k = 0; k < 60; k++) begin
         bit st, le, mis;
         logic [4:0]  f;
         logic [31:0] ea;
         st  = 1'($urandom);
         le  = 1'($urandom);
         mis = ($urandom_range(0, 5) == 0);
         f   = 5'($urandom);
         ea  = 32'h0000_1000 | ($urandom & 32'hFC);
         if (mis) ea[1:0] = 2'($urandom_range(1, 3));
         if (!st) for (int i = 0; i < 64; i++) mem[i] = $urandom;
         run_op(st, f, ea, le, ($urandom_range(0, 3) == 0), "R2 random");
      end
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule